// File: doc/BRIEF.md
# Ones' Complement Adder-Subtractor

This block adds or subtracts two N-bit signed numbers held in ones' complement form. The whole datapath is combinational: the result and its flags follow the operands and the operation select with no clock. A subtraction reuses the adder. Every bit of the second operand is inverted, which forms its negative in this number system, and the two values are then added.

The raw N-bit sum can carry out of its top bit. When it does, that carry is added back into the least significant bit as an end-around carry. Zero has two encodings, all zeros and all ones. The block raises a flag when the corrected sum is the all-ones form. A build-time option can rewrite that form to all zeros. A separate flag reports a signed overflow.

Top module: `oc_addsub`

## Requirements
- R1: With `sub` = 0, `y` encodes a + b whenever that sum lies within ±(2^(N−1)−1). A value with the top bit set decodes as minus the bitwise inverse of its bits.
- R2: With `sub` = 1, the second operand is inverted bit by bit before the add. `y` then encodes a − b whenever that difference lies within range.
- R3: A carry out of the top bit of the raw sum is added into bit 0. For example, at N=8, 00101011 − 00001101 yields 00011110. The correction step never produces a second carry out.
- R4: `ovf` is 1 exactly when a and the effective second operand share a sign bit (bit N−1) and the corrected sum's sign bit differs from it. This covers every result outside ±(2^(N−1)−1).
- R5: `ovf` is 0 whenever a and the effective second operand have different sign bits.
- R6: `neg_zero` is 1 exactly when the corrected sum is all ones. This happens for every zero result unless both effective operands are all zeros.
- R7: With parameter NORMALIZE_ZERO = 1, an all-ones corrected sum is driven on `y` as all zeros, and `neg_zero` still reports it. With NORMALIZE_ZERO = 0, `y` shows the all-ones value.
- R8: Adding two all-zero effective operands gives an all-zero `y`, with `ovf` = 0 and `neg_zero` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | First operand, ones' complement |
| b | input | N | Second operand, ones' complement |
| sub | input | 1 | 1 selects a − b, 0 selects a + b |
| y | output | N | Corrected result |
| ovf | output | 1 | Signed overflow |
| neg_zero | output | 1 | Corrected sum is the all-ones zero |

## Verification
Every result and flag is purely combinational, so each is due in the same cycle as the operands that produce it, with no register in the path. The bench drives a new operand pair just after each rising edge. It compares `y`, `ovf` and `neg_zero` against its integer model at the following falling edge, half a period later, when the logic has settled. Three instances run side by side on every clock. One is 8 bits wide and is swept through every operand pair in both operations. The other two are 4 bits wide, one for each setting of the zero option, and repeatedly cover all of their own pairs.

// File: rtl/ocadd_pkg.sv
package ocadd_pkg;

  // Signed overflow: the two addends agree in sign and the sum disagrees.
  function automatic logic sign_overflow(input logic sa, input logic sb, input logic ss);
    return (sa == sb) && (ss != sa);
  endfunction

  // Full-adder sum and carry for one bit position.
  function automatic logic fa_sum(input logic x, input logic y, input logic ci);
    return x ^ y ^ ci;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic ci);
    return (x & y) | (ci & (x ^ y));
  endfunction

endpackage

// File: rtl/oc_operand_prep.sv
module oc_operand_prep #(
  parameter int N = 8
) (
  input  logic [N-1:0] b,
  input  logic         sub,
  output logic [N-1:0] eb
);
  // Negation in ones' complement is a bitwise inversion.
  assign eb = b ^ {N{sub}};
endmodule

// File: rtl/oc_raw_adder.sv
module oc_raw_adder #(
  parameter int N = 8
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] z,
  output logic [N-1:0] raw_sum,
  output logic         raw_cout
);
  import ocadd_pkg::*;

  logic [N:0] chain;
  assign chain[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign raw_sum[i]  = fa_sum(x[i], z[i], chain[i]);
    assign chain[i+1]  = fa_carry(x[i], z[i], chain[i]);
  end

  assign raw_cout = chain[N];
endmodule

// File: rtl/oc_eac.sv
module oc_eac #(
  parameter int N              = 8,
  parameter bit NORMALIZE_ZERO = 1'b0
) (
  input  logic [N-1:0] raw_sum,
  input  logic         raw_cout,
  output logic [N-1:0] corr,
  output logic [N-1:0] y,
  output logic         neg_zero
);
  localparam logic [N-1:0] ALL_ONES = {N{1'b1}};

  logic         eac_cout;
  logic [N:0]   wide;

  assign wide     = {1'b0, raw_sum} + {{N{1'b0}}, raw_cout};
  assign eac_cout = wide[N];
  assign corr     = wide[N-1:0];
  assign neg_zero = (corr == ALL_ONES);

  if (NORMALIZE_ZERO) begin : g_norm
    assign y = neg_zero ? '0 : corr;
  end else begin : g_keep
    assign y = corr;
  end

  always_comb begin
    // R3: feeding the carry back in never carries out again
    p_no_second_carry_r3: assert (!eac_cout);
    // R3: a fed-back carry means the raw sum was below all ones
    p_raw_headroom_r3: assert (!raw_cout || (raw_sum != ALL_ONES));
  end
endmodule

// File: rtl/oc_addsub.sv
module oc_addsub #(
  parameter int N              = 8,
  parameter bit NORMALIZE_ZERO = 1'b0
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         sub,
  output logic [N-1:0] y,
  output logic         ovf,
  output logic         neg_zero
);
  import ocadd_pkg::*;

  localparam int MSB = N - 1;

  logic [N-1:0] eb;
  logic [N-1:0] raw_sum;
  logic         raw_cout;
  logic [N-1:0] corr;

  oc_operand_prep #(.N(N)) u_prep (
    .b   (b),
    .sub (sub),
    .eb  (eb)
  );

  oc_raw_adder #(.N(N)) u_add (
    .x        (a),
    .z        (eb),
    .raw_sum  (raw_sum),
    .raw_cout (raw_cout)
  );

  oc_eac #(.N(N), .NORMALIZE_ZERO(NORMALIZE_ZERO)) u_eac (
    .raw_sum  (raw_sum),
    .raw_cout (raw_cout),
    .corr     (corr),
    .y        (y),
    .neg_zero (neg_zero)
  );

  assign ovf = sign_overflow(a[MSB], eb[MSB], corr[MSB]);

  always_comb begin
    // R5: mixed-sign addends never overflow
    p_mixed_no_ovf_r5: assert ((a[MSB] == eb[MSB]) || !ovf);
    // R4: an overflow never coincides with the all-ones zero
    p_ovf_not_negzero_r4: assert (!(ovf && neg_zero));
    // R8: two all-zero addends give the all-zero result
    p_pos_zero_r8: assert (!((a == '0) && (eb == '0)) || ((y == '0) && !neg_zero && !ovf));
    // R7: a reported negative zero shows on y as all ones or, normalized, all zeros
    p_negzero_out_r7: assert (!neg_zero || (NORMALIZE_ZERO ? (y == '0) : (y == {N{1'b1}})));
  end
endmodule

// File: tb/sim_oc_addsub.sv
module sim_oc_addsub;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [7:0] a8, b8, y8;
  logic       s8, ov8, nz8;
  logic [3:0] a4, b4, y4, yn4;
  logic       s4, ov4, nz4, ovn4, nzn4;

  int checks = 0;
  int errors = 0;

  oc_addsub #(.N(8), .NORMALIZE_ZERO(1'b0)) u0 (
    .a(a8), .b(b8), .sub(s8), .y(y8), .ovf(ov8), .neg_zero(nz8));
  oc_addsub #(.N(4), .NORMALIZE_ZERO(1'b0)) u1 (
    .a(a4), .b(b4), .sub(s4), .y(y4), .ovf(ov4), .neg_zero(nz4));
  oc_addsub #(.N(4), .NORMALIZE_ZERO(1'b1)) u2 (
    .a(a4), .b(b4), .sub(s4), .y(yn4), .ovf(ovn4), .neg_zero(nzn4));

  function automatic int decode(int bits, int n);
    int mask = (1 << n) - 1;
    if (((bits >> (n - 1)) & 1) == 1) return -((~bits) & mask);
    return bits & mask;
  endfunction

  task automatic expect_eq(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Integer model: compute the mathematical result and the expected flags.
  task automatic model_check(int n, bit norm, int ai, int bi, bit s, int yv, bit ov, bit nz);
    int mask = (1 << n) - 1;
    int ebits = s ? ((~bi) & mask) : (bi & mask);
    int res = decode(ai, n) + decode(ebits, n);
    int lim = (1 << (n - 1)) - 1;
    bit mixed = ((ai >> (n - 1)) & 1) != ((ebits >> (n - 1)) & 1);
    bit both_pz = (ai == 0) && (ebits == 0);
    string vt = s ? "R2" : "R1";
    if (res > lim || res < -lim) begin
      expect_eq("R4", "ovf out of range", int'(ov), 1);
      expect_eq("R6", "neg_zero on overflow", int'(nz), 0);
    end else begin
      expect_eq(mixed ? "R5" : "R4", "ovf in range", int'(ov), 0);
      if (res == 0) begin
        expect_eq(both_pz ? "R8" : "R6", "neg_zero", int'(nz), both_pz ? 0 : 1);
        if (both_pz || norm) expect_eq(both_pz ? "R8" : "R7", "zero y bits", yv, 0);
        else                 expect_eq("R7", "zero y bits", yv, mask);
      end else begin
        expect_eq("R6", "neg_zero nonzero", int'(nz), 0);
        expect_eq(vt, "value", decode(yv, n), res);
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    a8 = '0; b8 = '0; s8 = 1'b0; a4 = '0; b4 = '0; s4 = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R8: idle inputs give positive zero, no flags
    expect_eq("R8", "idle y8", int'(y8), 0);
    expect_eq("R8", "idle flags8", int'({ov8, nz8}), 0);
    expect_eq("R8", "idle y4", int'(y4), 0);
    expect_eq("R8", "idle flags4n", int'({ovn4, nzn4}), 0);
    rst_n = 1'b1;

    // R3: end-around carry example
    @(posedge clk);
    a8 = 8'b00101011; b8 = 8'b00001101; s8 = 1'b1;
    @(negedge clk);
    expect_eq("R3", "eac example", int'(y8), int'(8'b00011110));

    // R6: x + (-x) gives all ones
    @(posedge clk);
    a8 = 8'd5; b8 = 8'd5; s8 = 1'b1;
    @(negedge clk);
    expect_eq("R6", "x-x bits", int'(y8), 255);
    expect_eq("R6", "x-x flag", int'(nz8), 1);

    // R4: +7 + +7 overflows at N=4
    @(posedge clk);
    a4 = 4'b0111; b4 = 4'b0111; s4 = 1'b0;
    @(negedge clk);
    expect_eq("R4", "max+max ovf", int'(ov4), 1);

    // R7: normalized negative zero
    @(posedge clk);
    a4 = 4'b0011; b4 = 4'b1100; s4 = 1'b0;
    @(negedge clk);
    expect_eq("R7", "norm y", int'(yn4), 0);
    expect_eq("R7", "norm flag", int'(nzn4), 1);
    expect_eq("R7", "plain y", int'(y4), 15);

    for (int i = 0; i < 131072; i++) begin
      @(posedge clk);
      a8 = i[15:8]; b8 = i[7:0]; s8 = i[16];
      a4 = i[7:4];  b4 = i[3:0]; s4 = i[8];
      @(negedge clk);
      model_check(8, 1'b0, int'(a8), int'(b8), s8, int'(y8), ov8, nz8);
      if (i < 1024) begin
        model_check(4, 1'b0, int'(a4), int'(b4), s4, int'(y4), ov4, nz4);
        model_check(4, 1'b1, int'(a4), int'(b4), s4, int'(yn4), ovn4, nzn4);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule